// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a byte-wide serial port that a small processor drives through a memory-mapped register file. It has a transmitter with a holding register and a shift register, and a receiver with 16x oversampling. A 16-bit divisor sets the oversampling tick rate, so the divisor equals clk/(16*baud) minus 1. Software selects 7 or 8 data bits, optional even or odd parity, and one or two stop bits. The transmit and receive directions each have their own command register with an enable bit and interrupt enables.

The line status and handshake status registers have two addresses each. Writing ones at the clear address clears those bits. Writing ones at the set address sets them. Software can also force a break on the output. The control register selects one of three modes. In local loopback the transmitter feeds the receiver internally. In auto-echo every received character is sent back out. The same register drives the DTR and RTS outputs. A single level interrupt output combines the enabled conditions.

Top module: `sio_port`

## Requirements
- R1: After reset the line status register (offset 0x00) reads 0x06 (bit2 holding empty, bit1 shifter empty), the control register (0x18) reads 0x00, txd is high and irq is low.
- R2: With divisor D (high byte at 0x10, low byte at 0x14) one bit lasts 16*(D+1) clocks. A transmitted frame is a low start bit, then the data bits LSB first, then the stop bits at high level.
- R3: Control bit3 selects 8 data bits (1) or 7 (0). Bit2 adds a parity bit, which is even when bit1 is 0 and odd when bit1 is 1. Bit0 selects two stop bits. The transmitter follows these settings.
- R4: A write to offset 0x24 loads the holding register. Line status bit2 reads 0 while the holding register is full, and bit1 reads 0 while a frame is shifting out. Transmission starts only while transmit command bit7 is set.
- R5: While receive command bit7 is set, a received character sets line status bit7 (data ready) and can be read at 0x24. The read clears bit7. With receive command bit5 set, irq is high while bit7 is set.
- R6: A wrong parity bit sets line status bit4. A low stop bit sets bit6. In both cases the character is still stored.
- R7: A character that completes while bit7 is still set sets bit5 (overrun), and the stored character is kept.
- R8: A receive line held low for a whole frame, stop bit included, sets bit3 (break) and bit6, and it does not set data ready.
- R9: Writing ones at 0x00 clears line status bits 7..3, and writing ones at 0x04 sets them. Bits 2, 1 and 0 ignore both writes.
- R10: Handshake status bit7 (at 0x08) is set by any change on dsr_in and bit6 by any change on cts_in. Both are cleared by ones written at 0x08 and set by ones written at 0x0C. Control bits 5 and 4 drive dtr_out and rts_out.
- R11: While transmit command bit1 is set, txd is held low.
- R12: With control bit6 (loopback) set, txd stays high and transmitted characters are received internally.
- R13: With control bit7 (auto-echo) set, every received character is transmitted again on txd.
- R14: A low pulse on rxd shorter than half a bit is rejected as a start bit and leaves the line status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| dsr_in | input | 1 | Data-set-ready handshake input |
| cts_in | input | 1 | Clear-to-send handshake input |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong tick counter or shifter state shows on txd within one frame, as a bit that is misplaced, inverted or stretched. The bench's frame monitor samples every bit at its centre and compares the result against a queue of expected characters. A wrong sticky flag or a wrong overrun decision shows at the next line status read after the frame, and that read always falls within a few dozen clocks of the stop bit. Mode errors show at the ports in the first frame that uses the mode. A loopback that leaks drives txd low, and an echo that fails leaves an expected character in the queue.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int unsigned REG_AW = 6;

    localparam logic [REG_AW-1:0] OFS_LSR_CLR = 6'h00;
    localparam logic [REG_AW-1:0] OFS_LSR_SET = 6'h04;
    localparam logic [REG_AW-1:0] OFS_HSR_CLR = 6'h08;
    localparam logic [REG_AW-1:0] OFS_HSR_SET = 6'h0C;
    localparam logic [REG_AW-1:0] OFS_DIVH    = 6'h10;
    localparam logic [REG_AW-1:0] OFS_DIVL    = 6'h14;
    localparam logic [REG_AW-1:0] OFS_CTRL    = 6'h18;
    localparam logic [REG_AW-1:0] OFS_RXCMD   = 6'h1C;
    localparam logic [REG_AW-1:0] OFS_TXCMD   = 6'h20;
    localparam logic [REG_AW-1:0] OFS_DATA    = 6'h24;

    // sticky line-status flags, index into a 5-bit vector that maps to bits 7..3
    localparam int unsigned ST_DR = 4;
    localparam int unsigned ST_FE = 3;
    localparam int unsigned ST_OE = 2;
    localparam int unsigned ST_PE = 1;
    localparam int unsigned ST_BK = 0;

    typedef struct packed {
        logic echo;
        logic loop;
        logic dtr;
        logic rts;
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } ctrl_t;

    typedef struct packed {
        logic len8;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        SH_IDLE, SH_START, SH_DATA, SH_PAR, SH_STOP, SH_HOLD
    } sh_state_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
        logic       brk;
    } rx_result_t;

    function automatic logic calc_par(logic [7:0] d, frame_cfg_t c);
        logic p;
        p = c.len8 ? ^d : ^d[6:0];
        return p ^ c.par_odd;
    endfunction

    function automatic logic [2:0] last_bit(frame_cfg_t c);
        return c.len8 ? 3'd7 : 3'd6;
    endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == '0) begin
            cnt <= div;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = (cnt == '0);

    // R2: with a nonzero divisor two ticks are never adjacent
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> !tick);

endmodule

// File: rtl/sio_tx.sv
module sio_tx
    import sio_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  frame_cfg_t cfg,
    input  logic       load,
    input  logic [7:0] load_data,
    output logic       line,
    output logic       busy
);
    localparam int unsigned TW = $clog2(OSR);

    sh_state_t     state;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          par;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            tcnt  <= '0;
            bidx  <= '0;
            shreg <= '0;
            par   <= 1'b0;
            line  <= 1'b1;
        end else if (state == SH_IDLE) begin
            line <= 1'b1;
            if (load) begin
                shreg <= load_data;
                par   <= calc_par(load_data, cfg);
                state <= SH_START;
                tcnt  <= '0;
                line  <= 1'b0;
            end
        end else if (tick) begin
            if (tcnt != TW'(OSR - 1)) begin
                tcnt <= tcnt + 1'b1;
            end else begin
                tcnt <= '0;
                case (state)
                    SH_START: begin
                        state <= SH_DATA;
                        bidx  <= '0;
                        line  <= shreg[0];
                    end
                    SH_DATA: begin
                        if (bidx == last_bit(cfg)) begin
                            bidx <= '0;
                            if (cfg.par_en) begin
                                state <= SH_PAR;
                                line  <= par;
                            end else begin
                                state <= SH_STOP;
                                line  <= 1'b1;
                            end
                        end else begin
                            bidx  <= bidx + 1'b1;
                            shreg <= shreg >> 1;
                            line  <= shreg[1];
                        end
                    end
                    SH_PAR: begin
                        state <= SH_STOP;
                        line  <= 1'b1;
                    end
                    default: begin
                        line <= 1'b1;
                        if (cfg.stop2 && bidx == 3'd0) begin
                            bidx <= 3'd1;
                        end else begin
                            state <= SH_IDLE;
                        end
                    end
                endcase
            end
        end
    end

    assign busy = (state != SH_IDLE);

    // R4: the shifter leaves idle only on a load request
    a_r4_busy_from_load: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load));

    // R2: the line rests high whenever no frame is in progress
    a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line);

endmodule

// File: rtl/sio_rx.sv
module sio_rx
    import sio_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       rx,
    input  frame_cfg_t cfg,
    output logic       done,
    output rx_result_t result
);
    localparam int unsigned TW  = $clog2(OSR);
    localparam int unsigned MID = OSR / 2;

    sh_state_t     state;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          zero;
    logic          perr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SH_IDLE;
            tcnt   <= '0;
            bidx   <= '0;
            shreg  <= '0;
            zero   <= 1'b0;
            perr   <= 1'b0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= SH_IDLE;
            end else begin
                case (state)
                    SH_IDLE: begin
                        if (!rx) begin
                            state <= SH_START;
                            tcnt  <= '0;
                        end
                    end
                    SH_START: begin
                        if (tick) begin
                            if (tcnt == TW'(MID - 1)) begin
                                if (rx) begin
                                    state <= SH_IDLE;
                                end else begin
                                    state <= SH_DATA;
                                    tcnt  <= '0;
                                    bidx  <= '0;
                                    shreg <= '0;
                                    zero  <= 1'b1;
                                    perr  <= 1'b0;
                                end
                            end else begin
                                tcnt <= tcnt + 1'b1;
                            end
                        end
                    end
                    SH_HOLD: begin
                        if (rx) state <= SH_IDLE;
                    end
                    default: begin
                        if (tick) begin
                            if (tcnt != TW'(OSR - 1)) begin
                                tcnt <= tcnt + 1'b1;
                            end else begin
                                tcnt <= '0;
                                if (rx) zero <= 1'b0;
                                case (state)
                                    SH_DATA: begin
                                        shreg[bidx] <= rx;
                                        if (bidx == last_bit(cfg)) begin
                                            state <= cfg.par_en ? SH_PAR : SH_STOP;
                                        end else begin
                                            bidx <= bidx + 1'b1;
                                        end
                                    end
                                    SH_PAR: begin
                                        perr  <= (rx != calc_par(shreg, cfg));
                                        state <= SH_STOP;
                                    end
                                    default: begin
                                        done        <= 1'b1;
                                        result.data <= cfg.len8 ? shreg : {1'b0, shreg[6:0]};
                                        result.perr <= cfg.par_en & perr;
                                        result.ferr <= !rx;
                                        result.brk  <= !rx & zero;
                                        state       <= rx ? SH_IDLE : SH_HOLD;
                                    end
                                endcase
                            end
                        end
                    end
                endcase
            end
        end
    end

    // R5: each character completes with a single-cycle strobe
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a break is always reported as a framing error too
    a_r8_break_is_frame_error: assert property (@(posedge clk) disable iff (rst)
        (done && result.brk) |-> result.ferr);

endmodule

// File: rtl/sio_port.sv
module sio_port
    import sio_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned OSR   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        rxd,
    output logic        txd,
    input  logic        dsr_in,
    input  logic        cts_in,
    output logic        dtr_out,
    output logic        rts_out,
    output logic        irq
);
    ctrl_t            ctrl;
    logic [7:0]       rxcmd, txcmd;
    logic [DIV_W-1:0] div;
    logic [4:0]       st;
    logic [1:0]       hsr;
    logic [7:0]       rbuf, hold, echo_byte;
    logic             hold_full, echo_pend;
    logic             rx_meta, rx_s;
    logic [2:0]       dsr_p, cts_p;

    logic       tick, tx_line, tx_busy, tx_load, int_line, rx_src, rx_done;
    logic [7:0] tx_data;
    rx_result_t rx_res;
    frame_cfg_t fcfg;
    logic [4:0] st_clr, st_set, st_hw;

    assign fcfg     = '{len8: ctrl.len8, par_en: ctrl.par_en, par_odd: ctrl.par_odd, stop2: ctrl.stop2};
    assign int_line = txcmd[1] ? 1'b0 : tx_line;
    assign txd      = ctrl.loop ? 1'b1 : int_line;
    assign rx_src   = ctrl.loop ? int_line : rxd;
    assign dtr_out  = ctrl.dtr;
    assign rts_out  = ctrl.rts;
    assign tx_load  = !tx_busy && (echo_pend || (hold_full && txcmd[7] && !ctrl.echo));
    assign tx_data  = echo_pend ? echo_byte : hold;

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .div(div), .tick(tick)
    );

    sio_tx #(.OSR(OSR)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(fcfg),
        .load(tx_load), .load_data(tx_data), .line(tx_line), .busy(tx_busy)
    );

    sio_rx #(.OSR(OSR)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .en(rxcmd[7]), .rx(rx_s),
        .cfg(fcfg), .done(rx_done), .result(rx_res)
    );

    always_comb begin
        st_clr = '0;
        st_set = '0;
        st_hw  = '0;
        if (bus_wr && bus_addr == OFS_LSR_CLR) st_clr = bus_wdata[7:3];
        if (bus_wr && bus_addr == OFS_LSR_SET) st_set = bus_wdata[7:3];
        if (bus_rd && bus_addr == OFS_DATA)    st_clr[ST_DR] = 1'b1;
        if (rx_done) begin
            if (rx_res.brk) begin
                st_hw[ST_BK] = 1'b1;
                st_hw[ST_FE] = 1'b1;
            end else if (st[ST_DR]) begin
                st_hw[ST_OE] = 1'b1;
            end else begin
                st_hw[ST_DR] = 1'b1;
                st_hw[ST_FE] = rx_res.ferr;
                st_hw[ST_PE] = rx_res.perr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            rxcmd     <= '0;
            txcmd     <= '0;
            div       <= '0;
            st        <= '0;
            hsr       <= '0;
            rbuf      <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            echo_byte <= '0;
            echo_pend <= 1'b0;
            rx_meta   <= 1'b1;
            rx_s      <= 1'b1;
            dsr_p     <= '0;
            cts_p     <= '0;
        end else begin
            rx_meta <= rx_src;
            rx_s    <= rx_meta;
            dsr_p   <= {dsr_p[1:0], dsr_in};
            cts_p   <= {cts_p[1:0], cts_in};

            st <= (st & ~st_clr) | st_set | st_hw;
            if (rx_done && !rx_res.brk && !st[ST_DR]) rbuf <= rx_res.data;

            if (tx_load) begin
                if (echo_pend) echo_pend <= 1'b0;
                else           hold_full <= 1'b0;
            end
            if (rx_done && !rx_res.brk && ctrl.echo) begin
                echo_pend <= 1'b1;
                echo_byte <= rx_res.data;
            end

            if (bus_wr) begin
                case (bus_addr)
                    OFS_HSR_CLR: hsr  <= hsr & ~bus_wdata[7:6];
                    OFS_HSR_SET: hsr  <= hsr | bus_wdata[7:6];
                    OFS_DIVH:    div[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
                    OFS_DIVL:    div[7:0] <= bus_wdata;
                    OFS_CTRL:    ctrl  <= bus_wdata;
                    OFS_RXCMD:   rxcmd <= bus_wdata;
                    OFS_TXCMD:   txcmd <= bus_wdata;
                    OFS_DATA: begin
                        hold      <= bus_wdata;
                        hold_full <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if (dsr_p[2] != dsr_p[1]) hsr[1] <= 1'b1;
            if (cts_p[2] != cts_p[1]) hsr[0] <= 1'b1;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_LSR_CLR, OFS_LSR_SET: bus_rdata = {st, !hold_full, !tx_busy, 1'b0};
            OFS_HSR_CLR, OFS_HSR_SET: bus_rdata = {hsr, 6'b0};
            OFS_DIVH:  bus_rdata = div[DIV_W-1:8];
            OFS_DIVL:  bus_rdata = div[7:0];
            OFS_CTRL:  bus_rdata = ctrl;
            OFS_RXCMD: bus_rdata = rxcmd;
            OFS_TXCMD: bus_rdata = txcmd;
            OFS_DATA:  bus_rdata = rbuf;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (rxcmd[5] & st[ST_DR])
               | (rxcmd[4] & (st[ST_FE] | st[ST_OE] | st[ST_PE] | st[ST_BK]))
               | (txcmd[5] & !hold_full)
               | (txcmd[4] & !hold_full & !tx_busy);

    // R7: an overrun keeps the stored character and raises the overrun flag
    a_r7_overrun_keeps_old: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_res.brk && st[ST_DR]) |=> ($stable(rbuf) && st[ST_OE]));

    // R5: a data read clears data ready unless a new character or a set lands
    a_r5_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_DATA && !rx_done) |=> !st[ST_DR]);

    // R9: writing one at the clear address removes the framing flag
    a_r9_w1c_frame: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_LSR_CLR && bus_wdata[6] && !rx_done) |=> !st[ST_FE]);

    // R8: a break never produces a data-ready event
    a_r8_break_no_ready: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rx_res.brk && !st[ST_DR]) |=> !st[ST_DR]);

endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd;
    logic       dsr_in = 1'b0, cts_in = 1'b0;
    logic       dtr_out, rts_out, irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam int BITCLK = 32; // divisor 1: tick every 2 clocks, 16 ticks per bit

    logic [7:0] exp_q[$];
    logic       mon_on = 1'b0;
    logic       m_len8 = 1'b1, m_par = 1'b0, m_odd = 1'b0, m_stop2 = 1'b0;

    always #5 clk = ~clk;

    sio_port u_sio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd),
        .dsr_in(dsr_in), .cts_in(cts_in), .dtr_out(dtr_out), .rts_out(rts_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic logic bpar(input logic [7:0] d, input logic l8, input logic odd);
        return (l8 ? ^d : ^d[6:0]) ^ odd;
    endfunction

    // driver: queue the expected character, then write it for transmission
    task automatic send_byte(input logic [7:0] d);
        exp_q.push_back(l8mask(d));
        wr(6'h24, d);
    endtask

    function automatic logic [7:0] l8mask(input logic [7:0] d);
        return m_len8 ? d : {1'b0, d[6:0]};
    endfunction

    task automatic wait_tx_idle();
        logic [7:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(6'h00, v);
            if ((v & 8'h06) == 8'h06) break;
            wclk(20);
        end
        wclk(40);
    endtask

    task automatic drive_frame(input logic [7:0] d, input logic l8, input logic pen,
                               input logic pbit, input logic stopv);
        @(negedge clk); rxd = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < (l8 ? 8 : 7); i++) begin
            rxd = d[i];
            repeat (BITCLK) @(negedge clk);
        end
        if (pen) begin
            rxd = pbit;
            repeat (BITCLK) @(negedge clk);
        end
        rxd = stopv;
        repeat (BITCLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BITCLK) @(negedge clk);
    endtask

    // monitor: decode frames on txd and compare against the queue
    initial begin
        logic [7:0] got;
        logic       pb, ok;
        forever begin
            @(negedge txd);
            if (mon_on) begin
                ok = 1'b1;
                got = '0;
                wclk(BITCLK / 2);
                if (txd !== 1'b0) ok = 1'b0;
                for (int i = 0; i < (m_len8 ? 8 : 7); i++) begin
                    wclk(BITCLK);
                    got[i] = txd;
                end
                if (m_par) begin
                    wclk(BITCLK);
                    pb = txd;
                    if (pb !== bpar(got, m_len8, m_odd)) ok = 1'b0;
                end
                wclk(BITCLK);
                if (txd !== 1'b1) ok = 1'b0;
                if (m_stop2) begin
                    wclk(BITCLK);
                    if (txd !== 1'b1) ok = 1'b0;
                end
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R3: actual frame %h expected none", got);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk("R3 frame data", got, e);
                    chk("R2 frame framing", {7'b0, ok}, 8'h01);
                end
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        wclk(5);
        @(negedge clk); rst = 1'b0;
        wclk(2);
        rd(6'h00, v); chk("R1 line status", v, 8'h06);
        rd(6'h18, v); chk("R1 control", v, 8'h00);
        chk("R1 txd/irq", {6'b0, txd, irq}, 8'h02);

        wr(6'h10, 8'h00); wr(6'h14, 8'h01);
        wr(6'h18, 8'h08); wr(6'h1C, 8'h80); wr(6'h20, 8'h80);
        mon_on = 1'b1;

        // R2 R4: two back-to-back writes, second one waits in the holding register
        send_byte(8'h55);
        wclk(3);
        send_byte(8'hA3);
        rd(6'h00, v); chk("R4 holding and shifter busy", v & 8'h06, 8'h00);
        wait_tx_idle();

        // R3: 7 bits even parity two stops, then 8 bits odd parity
        m_len8 = 1'b0; m_par = 1'b1; m_odd = 1'b0; m_stop2 = 1'b1;
        wr(6'h18, 8'h05);
        send_byte(8'h3A);
        wait_tx_idle();
        m_len8 = 1'b1; m_par = 1'b1; m_odd = 1'b1; m_stop2 = 1'b0;
        wr(6'h18, 8'h0E);
        send_byte(8'h81);
        wait_tx_idle();
        m_par = 1'b0; m_odd = 1'b0;
        wr(6'h18, 8'h08);

        // R5: receive with interrupt
        drive_frame(8'hC4, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(6'h00, v); chk("R5 ready set", v, 8'h86);
        wr(6'h1C, 8'hA0);
        wclk(1); chk("R5 irq on ready", {7'b0, irq}, 8'h01);
        rd(6'h24, v); chk("R5 data", v, 8'hC4);
        rd(6'h00, v); chk("R5 read clears ready", v, 8'h06);
        chk("R5 irq off", {7'b0, irq}, 8'h00);
        wr(6'h1C, 8'h80);

        // R6: parity error with 8E1
        wr(6'h18, 8'h0C);
        drive_frame(8'h37, 1'b1, 1'b1, ~bpar(8'h37, 1'b1, 1'b0), 1'b1);
        rd(6'h00, v); chk("R6 parity error", v, 8'h96);
        rd(6'h24, v); chk("R6 data kept", v, 8'h37);
        wr(6'h00, 8'h10);
        rd(6'h00, v); chk("R9 w1c parity", v, 8'h06);

        // R6: framing error
        wr(6'h18, 8'h08);
        drive_frame(8'h5B, 1'b1, 1'b0, 1'b0, 1'b0);
        rd(6'h00, v); chk("R6 framing error", v, 8'hC6);
        rd(6'h24, v); chk("R6 data with framing error", v, 8'h5B);
        wr(6'h00, 8'h40);

        // R7: overrun keeps first character
        drive_frame(8'h11, 1'b1, 1'b0, 1'b0, 1'b1);
        drive_frame(8'h22, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(6'h00, v); chk("R7 overrun", v, 8'hA6);
        rd(6'h24, v); chk("R7 old data kept", v, 8'h11);
        wr(6'h00, 8'h20);

        // R8: break
        @(negedge clk); rxd = 1'b0;
        repeat (12 * BITCLK) @(negedge clk);
        rxd = 1'b1;
        wclk(2 * BITCLK);
        rd(6'h00, v); chk("R8 break detect", v, 8'h4E);
        wr(6'h00, 8'h48);

        // R9: set and clear, low bits ignore writes
        wr(6'h00, 8'h07);
        rd(6'h00, v); chk("R9 low bits ignore clear", v, 8'h06);
        wr(6'h04, 8'hF9);
        rd(6'h00, v); chk("R9 set address", v, 8'hFE);
        wr(6'h00, 8'hF8);
        rd(6'h00, v); chk("R9 clear all", v, 8'h06);

        // R10: handshake flags and outputs
        dsr_in = 1'b1;
        wclk(6);
        rd(6'h08, v); chk("R10 dsr change", v, 8'h80);
        wr(6'h08, 8'h80);
        rd(6'h08, v); chk("R10 w1c handshake", v, 8'h00);
        wr(6'h0C, 8'h40);
        rd(6'h08, v); chk("R10 set handshake", v, 8'h40);
        wr(6'h08, 8'hFF);
        wr(6'h18, 8'h38);
        wclk(1); chk("R10 dtr rts", {6'b0, dtr_out, rts_out}, 8'h03);

        // R14: short glitch
        wr(6'h18, 8'h08);
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        wclk(12 * BITCLK);
        rd(6'h00, v); chk("R14 glitch rejected", v, 8'h06);

        // R11: break generation
        mon_on = 1'b0;
        wr(6'h20, 8'h82);
        wclk(2); chk("R11 break low", {7'b0, txd}, 8'h00);
        wclk(100); chk("R11 break held", {7'b0, txd}, 8'h00);
        wr(6'h20, 8'h80);
        wclk(2); chk("R11 break released", {7'b0, txd}, 8'h01);

        // R12: loopback
        wr(6'h18, 8'h48);
        wr(6'h24, 8'h5A);
        wclk(50); chk("R12 pin high mid frame", {7'b0, txd}, 8'h01);
        wclk(400);
        rd(6'h00, v); chk("R12 looped ready", v, 8'h86);
        rd(6'h24, v); chk("R12 looped data", v, 8'h5A);

        // R13: auto-echo
        wr(6'h18, 8'h88);
        wclk(4);
        mon_on = 1'b1;
        exp_q.push_back(8'h9C);
        drive_frame(8'h9C, 1'b1, 1'b0, 1'b0, 1'b1);
        wclk(400);
        rd(6'h24, v);
        chk("R13 echo sent", 8'(exp_q.size()), 8'h00);
        summary();
    end

endmodule